// File: doc/BRIEF.md
# Row Write Buffer with Program Timer

This block sits behind the serial protocol front end of a small non-volatile byte store. A write transfer opens when the front end hands over a start address. The data bytes that follow are gathered into a 16-slot row latch. A STOP then commits the gathered bytes to storage and holds a busy flag for the program time. A mode input chooses how the address runs on from byte to byte. In page mode the low four address bits wrap, so the transfer stays inside one 16-byte row. In multibyte mode the address counts freely for up to eight bytes and can run into the next row.

While the program cycle is running, the block drives one memory write command per latched byte. It also raises a long-cycle indication when a multibyte burst touched two rows, because that case takes twice the nominal program time. The program time is a count of system clocks set by a parameter. Storage is a behavioural byte array that comes out of reset erased to FFh. A combinational read port lets the surrounding logic read it. The protection logic and the bus protocol are outside this block. A variant parameter removes multibyte mode for parts that support page mode only.

Top module: `eeprom_write_buffer`

## Requirements
- R1: In page mode (mode_i = 0) each accepted byte goes to the address whose bits [10:4] equal those of the start address and whose bits [3:0] are the start's low bits plus the byte index, modulo 16. A 17th byte therefore overwrites the first.
- R2: In multibyte mode (mode_i = 1) byte k goes to start address + k, modulo 2048, so the burst may enter the next row. Only the first 8 bytes are kept and later bytes are discarded.
- R3: mode_i is sampled on the cycle in which addr_load_i is taken. Changing it during the data bytes has no effect on that transfer.
- R4: A transfer of a single data byte writes that byte at the start address in either mode and takes the nominal program time.
- R5: A stop_i that arrives while idle, after at least one byte, raises busy_o on the next cycle. busy_o then stays high for exactly PROG_CYCLES cycles, or twice that for a long cycle.
- R6: long_cycle_o is high throughout a program cycle, and only then, when a multibyte transfer wrote bytes in two different rows. The busy time is then 2*PROG_CYCLES. A page mode transfer never gives a long cycle.
- R7: During busy_o the block issues one mem_we_o pulse for each distinct latched address and commits every latched byte to storage. mem_we_o is never high while idle.
- R8: A stop_i with no bytes since the last address load, or any transfer ended by abort_i, leaves storage unchanged and busy_o low.
- R9: addr_load_i, byte_stb_i, stop_i and abort_i are ignored while busy_o is high. They write nothing, and they do not start another cycle after the current one.
- R10: After reset busy_o and long_cycle_o are low and every storage byte reads FFh.
- R11: In multibyte mode the address wraps from 7FFh to 000h. That step counts as entering a new row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Write mode: 1 multibyte, 0 page |
| addr_load_i | input | 1 | Opens a transfer at addr_i |
| addr_i | input | ADDR_W | Start address |
| byte_stb_i | input | 1 | One data byte is present on byte_i |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Bus STOP strobe |
| abort_i | input | 1 | Drops the open transfer |
| busy_o | output | 1 | Program cycle in progress |
| long_cycle_o | output | 1 | Current program cycle is the doubled one |
| mem_we_o | output | 1 | Storage write command |
| mem_waddr_o | output | ADDR_W | Storage write address |
| mem_wdata_o | output | 8 | Storage write data |
| rd_addr_i | input | ADDR_W | Storage read address |
| rd_data_o | output | 8 | Storage read data |

## Verification
The bench aims at the address arithmetic first. A page burst that starts near the end of a row must fold back to the row start, and a design that carries into bit 4 would write into the next row. Seventeen page bytes must overwrite the first slot. A multibyte burst of eleven bytes must stop at eight, and a burst starting at 7FEh must wrap to 000h; an incrementer that is too narrow or a missing cap would scribble beyond the burst. The busy length is measured against both nominal and doubled times, so a row-crossing detector that misfires gives the wrong count. Empty stops, aborts, inputs arriving during busy and a mode change in mid-transfer are each followed by a full scan of storage, which catches any stray write.

// File: rtl/ewb_pkg.sv
package ewb_pkg;
  localparam int DATA_W = 8;

  typedef enum logic {
    WM_PAGE  = 1'b0,
    WM_MULTI = 1'b1
  } wmode_e;
endpackage

// File: rtl/ewb_store.sv
module ewb_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ewb_collect.sv
module ewb_collect
  import ewb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int OFS_W  = 4,
  parameter int MB_MAX = 8,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_i,
  input  wmode_e            mode_i,
  input  logic              byte_i,
  input  logic [DW-1:0]     data_i,
  input  logic              close_i,
  input  logic              clear_i,
  input  logic [OFS_W-1:0]  rd_idx_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_vld_o,
  output logic [ADDR_W-1:0] base_o,
  output wmode_e            mode_o,
  output logic              crossed_o,
  output logic              any_o
);
  localparam int SLOTS = 1 << OFS_W;
  localparam int CNT_W = OFS_W + 1;

  logic              open_q, cross_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOTS-1:0]  vld_q;
  logic [ADDR_W-1:0] cur_q, base_q, cur_nxt;
  wmode_e            mode_q;
  logic [DW-1:0]     slot_q [SLOTS];
  logic [OFS_W-1:0]  ofs;
  logic              room, take;

  assign ofs  = cur_q[OFS_W-1:0];
  assign room = (mode_q == WM_PAGE) || (cnt_q < CNT_W'(MB_MAX));
  assign take = byte_i && open_q && room && !close_i && !load_i && !clear_i;

  always_comb begin
    if (mode_q == WM_MULTI) cur_nxt = cur_q + 1'b1;
    else                    cur_nxt = {cur_q[ADDR_W-1:OFS_W], ofs + 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      cross_q <= 1'b0;
      cnt_q   <= '0;
      vld_q   <= '0;
      cur_q   <= '0;
      base_q  <= '0;
      mode_q  <= WM_MULTI;
    end else if (clear_i) begin
      open_q  <= 1'b0;
      cross_q <= 1'b0;
      cnt_q   <= '0;
      vld_q   <= '0;
    end else if (load_i) begin
      open_q  <= 1'b1;
      cross_q <= 1'b0;
      cnt_q   <= '0;
      vld_q   <= '0;
      cur_q   <= start_i;
      base_q  <= start_i;
      mode_q  <= mode_i;
    end else if (close_i) begin
      open_q  <= 1'b0;
    end else if (take) begin
      vld_q[ofs] <= 1'b1;
      cur_q      <= cur_nxt;
      if (cnt_q != CNT_W'(SLOTS)) cnt_q <= cnt_q + 1'b1;
      // byte landing outside the start row makes the cycle a long one
      if (mode_q == WM_MULTI && cur_q[ADDR_W-1:OFS_W] != base_q[ADDR_W-1:OFS_W])
        cross_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (take) slot_q[ofs] <= data_i;
  end

  assign rd_data_o = slot_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign base_o    = base_q;
  assign mode_o    = mode_q;
  assign crossed_o = cross_q;
  assign any_o     = |vld_q;

  AST_PAGE_ROW_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && mode_q == WM_PAGE) |-> cur_q[ADDR_W-1:OFS_W] == base_q[ADDR_W-1:OFS_W]); // R1
  AST_MB_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == WM_MULTI) |-> cnt_q <= CNT_W'(MB_MAX)); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !any_o); // R8
  AST_PAGE_NO_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == WM_PAGE && !load_i) |=> !cross_q); // R6
endmodule

// File: rtl/ewb_timer.sv
module ewb_timer #(
  parameter int PROG_CYCLES = 40,
  parameter int SLOTS       = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     go_i,
  input  logic                     long_i,
  output logic                     busy_o,
  output logic                     long_o,
  output logic                     wr_act_o,
  output logic [$clog2(SLOTS)-1:0] wr_idx_o,
  output logic                     done_o
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int T_W   = $clog2(2 * PROG_CYCLES + 1);
  localparam logic [T_W-1:0] LIM_N = T_W'(PROG_CYCLES - 1);
  localparam logic [T_W-1:0] LIM_L = T_W'(2 * PROG_CYCLES - 1);

  logic           busy_q, long_q, last;
  logic [T_W-1:0] tmr_q;
  logic [IDX_W:0] idx_q;

  assign last     = busy_q && (tmr_q == (long_q ? LIM_L : LIM_N));
  assign wr_act_o = busy_q && !idx_q[IDX_W];
  assign wr_idx_o = idx_q[IDX_W-1:0];
  assign busy_o   = busy_q;
  assign long_o   = long_q;
  assign done_o   = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      long_q <= 1'b0;
      tmr_q  <= '0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        long_q <= long_i;
        tmr_q  <= '0;
        idx_q  <= '0;
      end
    end else begin
      tmr_q <= tmr_q + 1'b1;
      if (!idx_q[IDX_W]) idx_q <= idx_q + 1'b1;
      if (last) begin
        busy_q <= 1'b0;
        long_q <= 1'b0;
      end
    end
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |=> busy_q); // R5
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> !busy_q); // R5
  AST_LONG_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_q |-> busy_q); // R6
  AST_LONG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |=> $stable(long_q)); // R6
endmodule

// File: rtl/eeprom_write_buffer.sv
module eeprom_write_buffer
  import ewb_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int OFS_W       = 4,
  parameter int MB_MAX      = 8,
  parameter int PROG_CYCLES = 40,
  parameter bit PAGE_ONLY   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_stb_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              long_cycle_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int SLOTS = 1 << OFS_W;
  localparam int ROW_W = ADDR_W - OFS_W;

  wmode_e            mode_eff, mode_q;
  logic              busy, done, any, crossed;
  logic              load_g, byte_g, close_g, clear_g, go;
  logic              wr_act, slot_vld;
  logic [OFS_W-1:0]  wr_idx;
  logic [DATA_W-1:0] slot_data;
  logic [ADDR_W-1:0] base;
  logic [ROW_W-1:0]  wr_row;

  generate
    if (PAGE_ONLY) begin : g_page_only
      assign mode_eff = WM_PAGE;
    end else begin : g_both_modes
      assign mode_eff = wmode_e'(mode_i);
    end
  endgenerate

  assign load_g  = addr_load_i & ~busy;
  assign byte_g  = byte_stb_i & ~busy;
  assign close_g = stop_i & ~busy;
  assign clear_g = (abort_i & ~busy) | done;
  assign go      = close_g & any;

  ewb_collect #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .MB_MAX(MB_MAX), .DW(DATA_W)
  ) u_collect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_g),
    .start_i  (addr_i),
    .mode_i   (mode_eff),
    .byte_i   (byte_g),
    .data_i   (byte_i),
    .close_i  (close_g),
    .clear_i  (clear_g),
    .rd_idx_i (wr_idx),
    .rd_data_o(slot_data),
    .rd_vld_o (slot_vld),
    .base_o   (base),
    .mode_o   (mode_q),
    .crossed_o(crossed),
    .any_o    (any)
  );

  ewb_timer #(
    .PROG_CYCLES(PROG_CYCLES), .SLOTS(SLOTS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .long_i  (mode_q == WM_MULTI && crossed),
    .busy_o  (busy),
    .long_o  (long_cycle_o),
    .wr_act_o(wr_act),
    .wr_idx_o(wr_idx),
    .done_o  (done)
  );

  // slots below the start offset belong to the following row in multibyte mode
  always_comb begin
    wr_row = base[ADDR_W-1:OFS_W];
    if (mode_q == WM_MULTI && wr_idx < base[OFS_W-1:0]) wr_row = wr_row + 1'b1;
  end

  assign mem_we_o    = wr_act & slot_vld;
  assign mem_waddr_o = {wr_row, wr_idx};
  assign mem_wdata_o = slot_data;
  assign busy_o      = busy;

  ewb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we_o),
    .waddr_i(mem_waddr_o),
    .wdata_i(mem_wdata_o),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );

  AST_GO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> busy_o); // R5
  AST_EMPTY_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && !any) |=> !busy_o); // R8
  AST_WE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o); // R7
  AST_PAGE_SAME_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mode_q == WM_PAGE) |-> mem_waddr_o[ADDR_W-1:OFS_W] == base[ADDR_W-1:OFS_W]); // R1
  AST_PAGE_NOT_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q == WM_PAGE) |-> !long_cycle_o); // R6
endmodule

// File: tb/eeprom_write_buffer_test.sv
module eeprom_write_buffer_test;
  localparam int AW = 11;
  localparam int T  = 20;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          mode_i, addr_load_i, byte_stb_i, stop_i, abort_i;
  logic [AW-1:0] addr_i, rd_addr_i;
  logic [7:0]    byte_i, rd_data_o, mem_wdata_o;
  logic          busy_o, long_cycle_o, mem_we_o;
  logic [AW-1:0] mem_waddr_o;

  eeprom_write_buffer #(.ADDR_W(AW), .PROG_CYCLES(T)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i), .addr_load_i(addr_load_i),
    .addr_i(addr_i), .byte_stb_i(byte_stb_i), .byte_i(byte_i), .stop_i(stop_i),
    .abort_i(abort_i), .busy_o(busy_o), .long_cycle_o(long_cycle_o),
    .mem_we_o(mem_we_o), .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  typedef struct packed {
    logic        mb;
    logic [10:0] start;
    logic [4:0]  n;
    logic [7:0]  seed;
    logic        long_e;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 11'h120, 5'd1,  8'h11, 1'b0},  // R4 page single
    '{1'b1, 11'h128, 5'd1,  8'h22, 1'b0},  // R4 multi single
    '{1'b0, 11'h13C, 5'd6,  8'h33, 1'b0},  // R1 wrap in row
    '{1'b0, 11'h200, 5'd17, 8'h44, 1'b0},  // R1 17th overwrites
    '{1'b1, 11'h30C, 5'd8,  8'h55, 1'b1},  // R2 R6 crosses row
    '{1'b1, 11'h400, 5'd8,  8'h66, 1'b0},  // R2 aligned
    '{1'b1, 11'h500, 5'd11, 8'h77, 1'b0},  // R2 cap at 8
    '{1'b1, 11'h7FE, 5'd3,  8'h88, 1'b1},  // R11 top wrap
    '{1'b0, 11'h6F8, 5'd12, 8'h99, 1'b0}   // R1 page long burst
  };

  logic [7:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int k);
    return seed + 8'(k * 7);
  endfunction

  task automatic model_apply(input logic mb, input logic [10:0] a, input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      logic [10:0] w;
      if (mb) begin
        if (k >= 8) break;
        w = a + 11'(k);
      end else begin
        w = {a[10:4], 4'(a[3:0] + 4'(k))};
      end
      model[w] = dbyte(seed, k);
    end
  endtask

  task automatic check_mem(input string req);
    int bad = 0;
    int fa = 0;
    int fv = 0;
    int fe = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr_i = AW'(a);
      #0.1;
      if (rd_data_o !== model[a]) begin
        if (bad == 0) begin fa = a; fv = rd_data_o; fe = model[a]; end
        bad++;
      end
    end
    if (bad != 0) $display("  first storage mismatch at %0h", fa);
    chk(bad == 0, req, fv, fe);
  endtask

  task automatic pulse_load(input logic mb, input logic [10:0] a);
    mode_i = mb; addr_i = a; addr_load_i = 1'b1;
    @(negedge clk);
    addr_load_i = 1'b0;
  endtask

  task automatic pulse_byte(input logic [7:0] d);
    byte_i = d; byte_stb_i = 1'b1;
    @(negedge clk);
    byte_stb_i = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  // counts busy cycles and write pulses from the negedge after the stop edge
  task automatic measure(output int len, output int we, output int long_bad);
    len = 0; we = 0; long_bad = 0;
    while (busy_o === 1'b1 && len < 1000) begin
      len++;
      if (mem_we_o === 1'b1) we++;
      if (long_cycle_o === 1'b1) long_bad++;
      @(negedge clk);
    end
  endtask

  task automatic idle_cycles(input int n, input string req);
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      if (busy_o !== 1'b0 || mem_we_o !== 1'b0) hi++;
      @(negedge clk);
    end
    chk(hi == 0, req, hi, 0);
  endtask

  task automatic run_xfer(input logic mb, input logic [10:0] a, input int n,
                          input logic [7:0] seed, input logic flip_mode,
                          input logic long_e, input string req);
    int len, we, lc, exp_len, exp_we;
    pulse_load(mb, a);
    if (flip_mode) mode_i = ~mb;
    for (int k = 0; k < n; k++) pulse_byte(dbyte(seed, k));
    pulse_stop();
    measure(len, we, lc);
    exp_len = long_e ? 2 * T : T;
    exp_we  = mb ? ((n < 8) ? n : 8) : ((n < 16) ? n : 16);
    chk(len == exp_len, {req, " busy length"}, len, exp_len);
    chk(lc == (long_e ? exp_len : 0), {req, " long_cycle_o"}, lc, long_e ? exp_len : 0);
    chk(we == exp_we, {req, " R7 write pulses"}, we, exp_we);
    model_apply(mb, a, n, seed);
    check_mem({req, " R7 storage"});
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_flag) begin
      done_flag = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected run end", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int len, we, lc;
    rst_n = 1'b0; mode_i = 1'b1; addr_load_i = 1'b0; byte_stb_i = 1'b0;
    stop_i = 1'b0; abort_i = 1'b0; addr_i = '0; byte_i = '0; rd_addr_i = '0;
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy_o === 1'b0, "R10 busy after reset", busy_o, 0);
    chk(long_cycle_o === 1'b0, "R10 long after reset", long_cycle_o, 0);
    check_mem("R10 erased content");
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t vv = VECS[v];
      run_xfer(vv.mb, vv.start, int'(vv.n), vv.seed, 1'b0, vv.long_e,
               vv.mb ? "R2 R5 R6 multibyte" : "R1 R5 page");
    end

    // R3: mode sampled at load, later changes ignored
    run_xfer(1'b1, 11'h0FC, 6, 8'hA1, 1'b1, 1'b1, "R3 multi then mode low");
    run_xfer(1'b0, 11'h0EC, 6, 8'hB2, 1'b1, 1'b0, "R3 page then mode high");

    // R8: stop with no bytes
    pulse_load(1'b1, 11'h050);
    pulse_stop();
    idle_cycles(T + 4, "R8 empty stop starts no cycle");
    check_mem("R8 empty stop storage");

    // R8: abort drops latched bytes
    pulse_load(1'b0, 11'h060);
    pulse_byte(8'h5A);
    pulse_byte(8'h5B);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    pulse_stop();
    idle_cycles(T + 4, "R8 abort starts no cycle");
    check_mem("R8 abort storage");

    // R9: inputs during busy are ignored
    pulse_load(1'b1, 11'h080);
    pulse_byte(8'hC3);
    pulse_byte(8'hC4);
    pulse_stop();
    addr_i = 11'h090; mode_i = 1'b1; addr_load_i = 1'b1;
    @(negedge clk);
    addr_load_i = 1'b0; byte_i = 8'hEE; byte_stb_i = 1'b1;
    @(negedge clk);
    byte_stb_i = 1'b0; stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0; abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    measure(len, we, lc);
    chk(len == T - 4, "R9 busy length with inputs", len, T - 4);
    idle_cycles(T + 4, "R9 no follow-on cycle");
    model_apply(1'b1, 11'h080, 2, 8'h00);
    model[11'h080] = 8'hC3;
    model[11'h081] = 8'hC4;
    check_mem("R9 storage after busy inputs");

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule